// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block sits between eight peripheral interrupt request lines and an 8-bit processor that signals when it is fetching an interrupt vector. It merges the requests into one active-low interrupt line using logic, not a wired-OR connection. It encodes the highest-priority pending source and holds the result in a register that loads on the falling clock edge. The held value is therefore settled before the processor samples data in the following high phase.

When the processor reads the low byte of its interrupt vector, the block disables normal memory and drives a byte that depends on the source. That byte points into a table of two-byte handler pointers, so each source reaches its own service routine without any change to the processor.

The high byte of the vector is always read from memory. The held priority result is frozen from the first vector read until the processor drops its vector-pull signal. A request that arrives mid-fetch therefore cannot split the address.

Top module: `vic_top`

## Requirements
- R1: `irqN` is low in every cycle in which at least one bit of `irqReq` is high, and high when all bits are low.
- R2: When several requests are pending, the source with the largest index wins. Bit 7 has the highest priority and bit 0 the lowest.
- R3: The substituted byte is `VEC_BASE` (default 8'hE0) with the winning source's 3-bit index placed in bits 3:1 and bit 0 cleared. Its value is 8'hE0 + 2*index.
- R4: Substitution takes place only when `vecPull`=1, `addr0`=0, `rdStrobe`=1 and a held request is pending. During substitution `memDisable`=1 and `dataOe`=1. At all other times both are 0 and `dataOut` is 8'h00, meaning the bus is released.
- R5: A vector read with `addr0`=1 (the high byte) is never substituted.
- R6: A vector low-byte read with no pending request held gives `dataOe`=0 and `memDisable`=0, so the default memory vector is used.
- R7: The priority register loads on the falling edge of `clk`. A request pattern applied after a rising edge is reflected in the substituted byte before the next rising edge.
- R8: From the first falling edge at which `vecPull` and `rdStrobe` are both high, the held source does not change until a falling edge sees `vecPull`=0. This holds even while `rdStrobe` drops between the two byte reads.
- R9: After reset the held result is "no request pending", so a vector low-byte read is not substituted until the register has loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; the priority register loads on its falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| irqReq | input | 8 | Active-high peripheral requests, bit 7 highest priority |
| vecPull | input | 1 | High while the processor fetches an interrupt vector |
| addr0 | input | 1 | Address bit 0; 0 selects the vector low byte |
| rdStrobe | input | 1 | High during a processor read |
| irqN | output | 1 | Merged active-low interrupt to the processor |
| dataOut | output | 8 | Substituted vector low byte, 0 when not driving |
| dataOe | output | 1 | Output enable for the data-bus buffer |
| memDisable | output | 1 | Disables normal memory during substitution |

## Verification
The bench applies all 256 request patterns. Each one is followed by a low-byte read and then a high-byte read, which separates correct priority order from a reversed or mis-shifted encoding and separates low-byte reads from high-byte reads. The all-zero pattern shows that no request leaves memory in control. A stream of rising single-bit and mixed patterns applied during a held vector fetch separates a correctly frozen register from one that keeps tracking the inputs. A read taken just after the falling edge that follows a new pattern confirms that the register loads on that edge.

// File: rtl/vic_pkg.sv
package vic_pkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic latchEn;     // priority register may load at the next falling edge
    logic substitute;  // drive the vector byte and disable memory
  } vicCtrl_t;
endpackage

// File: rtl/vic_datapath.sv
module vic_datapath #(
  parameter int NUM_SRC = 8,
  parameter logic [7:0] VEC_BASE = 8'hE0,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   irqReq,
  input  vic_pkg::vicCtrl_t    ctrl,
  output logic                 heldValid,
  output logic [7:0]           dataOut
);
  localparam logic [7:0] IDX_MASK = 8'(((1 << IDX_W) - 1) << 1) | 8'h01;

  logic [IDX_W-1:0] encIdx;
  logic             encValid;
  logic [IDX_W-1:0] heldIdx;

  // Priority encoder: the highest index wins
  always_comb begin
    encIdx   = '0;
    encValid = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (irqReq[i]) begin
        encIdx   = IDX_W'(i);
        encValid = 1'b1;
      end
    end
  end

  // Held result, loaded on the inverted clock phase
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      heldIdx   <= '0;
      heldValid <= 1'b0;
    end else if (ctrl.latchEn) begin
      heldIdx   <= encIdx;
      heldValid <= encValid;
    end
  end

  always_comb begin
    dataOut = 8'h00;
    if (ctrl.substitute)
      dataOut = (VEC_BASE & ~IDX_MASK) | (8'(heldIdx) << 1);
  end

  // R8: the held result changes only when control allows a load
  a_r8_hold_when_blocked: assert property (@(negedge clk) disable iff (!rstN)
    !ctrl.latchEn |=> $stable(heldIdx) && $stable(heldValid));
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl (
  input  logic               clk,
  input  logic               rstN,
  input  logic               vecPull,
  input  logic               addr0,
  input  logic               rdStrobe,
  input  logic               heldValid,
  output vic_pkg::vicCtrl_t  ctrl
);
  logic frozen;

  // Set on the first vector read, cleared once vector-pull ends
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN)        frozen <= 1'b0;
    else if (vecPull) frozen <= frozen | rdStrobe;
    else              frozen <= 1'b0;
  end

  always_comb begin
    ctrl.latchEn    = !vecPull || !(frozen || rdStrobe);
    ctrl.substitute = vecPull && !addr0 && rdStrobe && heldValid;
  end

  // R8: while frozen and vector-pull is still high, loading is blocked
  a_r8_frozen_blocks: assert property (@(negedge clk) disable iff (!rstN)
    (frozen && vecPull) |-> !ctrl.latchEn);
endmodule

// File: rtl/vic_top.sv
module vic_top #(
  parameter int NUM_SRC = 8,
  parameter logic [7:0] VEC_BASE = 8'hE0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               vecPull,
  input  logic               addr0,
  input  logic               rdStrobe,
  output logic               irqN,
  output logic [7:0]         dataOut,
  output logic               dataOe,
  output logic               memDisable
);
  vic_pkg::vicCtrl_t ctrl;
  logic heldValid;

  assign irqN = ~(|irqReq);

  vic_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .vecPull(vecPull), .addr0(addr0),
    .rdStrobe(rdStrobe), .heldValid(heldValid), .ctrl(ctrl)
  );

  vic_datapath #(.NUM_SRC(NUM_SRC), .VEC_BASE(VEC_BASE)) u_dp (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .ctrl(ctrl),
    .heldValid(heldValid), .dataOut(dataOut)
  );

  assign dataOe     = ctrl.substitute;
  assign memDisable = ctrl.substitute;

  // R5: a high-byte vector read is never substituted
  a_r5_high_byte_memory: assert property (@(posedge clk) disable iff (!rstN)
    (vecPull && addr0) |-> (!dataOe && !memDisable));
  // R4: the bus is released whenever the buffer is off
  a_r4_released_bus: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> (dataOut == 8'h00));
  // R3: the substituted byte is always even
  a_r3_even_slot: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> !dataOut[0]);
  // R6: without a pending source, memory is never disabled
  a_r6_no_pending: assert property (@(posedge clk) disable iff (!rstN)
    !heldValid |-> !memDisable);
endmodule

// File: tb/tb_vic_top.sv
module tb_vic_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] irqReq = '0;
  logic vecPull = 1'b0, addr0 = 1'b0, rdStrobe = 1'b0;
  logic irqN, dataOe, memDisable;
  logic [7:0] dataOut;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vic_top dut (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .vecPull(vecPull),
    .addr0(addr0), .rdStrobe(rdStrobe), .irqN(irqN), .dataOut(dataOut),
    .dataOe(dataOe), .memDisable(memDisable)
  );

  function automatic logic [7:0] expByte(input logic [7:0] r);
    int top = 0;
    for (int i = 0; i < 8; i++) if (r[i]) top = i;
    return 8'hE0 + 8'(2 * top);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive after a rising edge, then settle past the falling edge
  task automatic step(input logic [7:0] r, input logic vp, input logic a0, input logic rd);
    @(posedge clk);
    #0.5;
    irqReq = r; vecPull = vp; addr0 = a0; rdStrobe = rd;
    @(negedge clk);
    #0.5;
  endtask

  initial begin
    #1;
    // R9: reset state
    chk("R9 oe", dataOe, 0);
    chk("R9 memDisable", memDisable, 0);
    chk("R1 irqN idle", irqN, 1);
    repeat (2) @(posedge clk);
    rstN = 1'b1;
    step(8'h00, 1, 0, 1);
    chk("R9/R6 no pending after reset", {dataOe, memDisable, dataOut}, 0);
    step(8'h00, 0, 0, 0);

    // Sweep of all request patterns
    for (int p = 0; p < 256; p++) begin
      step(8'(p), 0, 0, 0);
      chk("R1 irqN", irqN, (p == 0) ? 1 : 0);
      chk("R4 idle release", {dataOe, memDisable, dataOut}, 0);
      step(8'(p), 1, 0, 1);
      if (p == 0) begin
        chk("R6 no substitution", {dataOe, memDisable}, 0);
      end else begin
        chk("R2/R3 byte", dataOut, expByte(8'(p)));
        chk("R4 enables", {dataOe, memDisable}, 2'b11);
      end
      step(8'(p), 1, 1, 1);
      chk("R5 high byte from memory", {dataOe, memDisable, dataOut}, 0);
      step(8'(p), 0, 0, 1);
      chk("R4 plain read not substituted", {dataOe, memDisable}, 0);
    end

    // R7: a new pattern is loaded at the falling edge and used before the next rise
    step(8'h01, 0, 0, 0);
    step(8'h40, 1, 0, 0);
    rdStrobe = 1'b1;
    #0.5;
    chk("R7 falling-edge load", dataOut, 8'hEC);
    step(8'h40, 0, 0, 0);

    // R8: freeze during a vector fetch
    step(8'h02, 0, 0, 0);
    step(8'h02, 1, 0, 1);
    chk("R8 initial pick", dataOut, 8'hE2);
    for (int b = 2; b < 8; b++) begin
      step(8'(1 << b), 1, 0, 1);
      chk("R8 frozen while reading", dataOut, 8'hE2);
    end
    step(8'hFF, 1, 1, 0);
    step(8'hFF, 1, 0, 1);
    chk("R8 frozen across gap", dataOut, 8'hE2);
    step(8'h80, 0, 0, 0);
    step(8'h80, 1, 0, 1);
    chk("R8 released after vecPull", dataOut, 8'hEE);
    step(8'h00, 0, 0, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule